// File: doc/BRIEF.md
# Reversible LED Rotator

This block walks a single lit LED across a row of outputs. While an enable switch is on, a timebase divider produces one tick every `TICK_CYCLES` clocks (one second at the intended clock rate), and each tick moves the lit position one place in the current direction. The position wraps around at both ends. A push button, or a REVERSE request on the command port, flips the direction of travel.

A small request port accepts READ, WRITE and REVERSE operations from a host. READ answers with the current position. WRITE loads a new position. A second push button asks for the number of timer steps made since the most recent reversal. Answers leave on a response port with a valid/ready handshake and a kind code, so the host can tell a position answer from a step-count answer.

Top module: `led_rotator`

## Requirements
- R1: While the synchronised enable switch is off, the position does not move; the divider restarts from zero each time the switch turns on.
- R2: After reset the position is 0, the direction is upward and `led` equals 1. With the switch on, the position moves by one every `TICK_CYCLES` clocks. `led` is always 1 shifted left by the position.
- R3: Stepping upward from `NUM_LEDS-1` gives 0. Stepping downward from 0 gives `NUM_LEDS-1`.
- R4: Buttons pass through a two-stage synchroniser and act on the rising edge only. One press of `btn_reverse` flips the direction exactly once, however long the button is held.
- R5: `cmd_op` = 3 (REVERSE) flips the direction just as the button does. Any reversal, from either source, clears the step count to 0.
- R6: `cmd_op` = 1 (READ) produces a response with `rsp_kind` = 1 and `rsp_data` equal to the current position.
- R7: `cmd_op` = 2 (WRITE) sets the position to `cmd_arg` when `cmd_arg` is at most `NUM_LEDS-1`. A larger value leaves the position unchanged. `cmd_op` = 0 does nothing.
- R8: A press of `btn_report` produces a response with `rsp_kind` = 2 and `rsp_data` equal to the number of timer steps since the last reversal. WRITE does not add to this count. The count saturates at its maximum value.
- R9: A response stays valid, with stable kind and data, until `rsp_ready` is high. While a response is waiting, `cmd_ready` is low and requests are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_sw | input | 1 | Run switch, asynchronous |
| btn_reverse | input | 1 | Direction button, asynchronous |
| btn_report | input | 1 | Step-count request button, asynchronous |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Request accepted when high together with cmd_valid |
| cmd_op | input | 2 | 0 none, 1 READ, 2 WRITE, 3 REVERSE |
| cmd_arg | input | ARG_W | Position for WRITE |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_kind | output | 2 | 1 position, 2 step count |
| rsp_data | output | CNT_W | Response value |
| led | output | NUM_LEDS | One-hot LED drive |

## Verification
A wrong direction bit shows up at `led` on the very next tick, which moves the wrong way. A step counter that is not cleared, or that counts writes, shows up only when a report is requested, so the bench requests reports right after reversals and right after writes. A bad divider shows up as a gap between LED changes that is not `TICK_CYCLES`, and this is measured as soon as two consecutive moves have been seen. A response register that is overwritten while it is pending shows up as data that changes while `rsp_ready` is held low.

// File: rtl/led_rotator.sv
module led_rotator #(
  parameter int NUM_LEDS    = 8,
  parameter int TICK_CYCLES = 125_000_000,
  parameter int ARG_W       = 8,
  parameter int CNT_W       = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable_sw,
  input  logic                btn_reverse,
  input  logic                btn_report,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [1:0]          cmd_op,
  input  logic [ARG_W-1:0]    cmd_arg,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [1:0]          rsp_kind,
  output logic [CNT_W-1:0]    rsp_data,
  output logic [NUM_LEDS-1:0] led
);

  localparam int IDX_W = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1;
  localparam int TW    = $clog2(TICK_CYCLES + 1);
  localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(NUM_LEDS - 1);
  localparam logic [ARG_W-1:0] ARG_MAX  = ARG_W'(NUM_LEDS - 1);
  localparam logic [TW-1:0]    TICK_END = TW'(TICK_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;

  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_WRITE = 2'd2;
  localparam logic [1:0] OP_REV   = 2'd3;
  localparam logic [1:0] KIND_POS = 2'd1;
  localparam logic [1:0] KIND_CNT = 2'd2;

  logic [1:0]       en_sh;
  logic [2:0]       rev_sh, rep_sh;
  logic [TW-1:0]    tcnt;
  logic [IDX_W-1:0] pos;
  logic             dir_down;
  logic [CNT_W-1:0] steps;
  logic             pend_report;
  logic             rsp_valid_q;
  logic [1:0]       rsp_kind_q;
  logic [CNT_W-1:0] rsp_data_q;

  wire en_on      = en_sh[1];
  wire rev_press  = rev_sh[1] & ~rev_sh[2];
  wire rep_press  = rep_sh[1] & ~rep_sh[2];
  wire tick       = en_on && (tcnt == TICK_END);
  wire cmd_fire   = cmd_valid && cmd_ready;
  wire do_read    = cmd_fire && (cmd_op == OP_READ);
  wire do_write   = cmd_fire && (cmd_op == OP_WRITE) && (cmd_arg <= ARG_MAX);
  wire do_rev     = rev_press || (cmd_fire && (cmd_op == OP_REV));

  wire [IDX_W-1:0] pos_up = (pos == TOP_IDX) ? '0 : pos + IDX_W'(1);
  wire [IDX_W-1:0] pos_dn = (pos == '0) ? TOP_IDX : pos - IDX_W'(1);

  assign cmd_ready = !rsp_valid_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_kind  = rsp_kind_q;
  assign rsp_data  = rsp_data_q;
  assign led       = NUM_LEDS'(1) << pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_sh  <= '0;
      rev_sh <= '0;
      rep_sh <= '0;
    end else begin
      en_sh  <= {en_sh[0], enable_sw};
      rev_sh <= {rev_sh[1:0], btn_reverse};
      rep_sh <= {rep_sh[1:0], btn_report};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tcnt <= '0;
    else if (!en_on) tcnt <= '0;
    else if (tick)   tcnt <= '0;
    else             tcnt <= tcnt + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      dir_down <= 1'b0;
      steps    <= '0;
    end else begin
      if (do_write)  pos <= cmd_arg[IDX_W-1:0];
      else if (tick) pos <= dir_down ? pos_dn : pos_up;
      if (do_rev) dir_down <= ~dir_down;
      if (do_rev)                         steps <= '0;
      else if (tick && steps != CNT_SAT)  steps <= steps + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_report <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_kind_q  <= '0;
      rsp_data_q  <= '0;
    end else begin
      if (rsp_valid_q && rsp_ready) rsp_valid_q <= 1'b0;
      if (rep_press) pend_report <= 1'b1;
      if (!rsp_valid_q) begin
        if (do_read) begin
          rsp_valid_q <= 1'b1;
          rsp_kind_q  <= KIND_POS;
          rsp_data_q  <= CNT_W'(pos);
        end else if (pend_report || rep_press) begin
          rsp_valid_q <= 1'b1;
          rsp_kind_q  <= KIND_CNT;
          rsp_data_q  <= steps;
          pend_report <= 1'b0;
        end
      end
    end
  end

  // R2: output pattern always has exactly one bit set
  always_comb begin
    if (rst_n) p_onehot_r2: assert ($onehot(led));
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_on && !do_write) |=> $stable(pos));

  p_wrap_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !dir_down && !do_write && pos == TOP_IDX) |=> (pos == '0));

  p_wrap_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dir_down && !do_write && pos == '0) |=> (pos == TOP_IDX));

  p_rev_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    do_rev |=> (steps == '0));

  p_bad_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_op == OP_WRITE && cmd_arg > ARG_MAX && !tick) |=> $stable(pos));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_kind) && $stable(rsp_data)));

endmodule

// File: tb/led_rotator_tb.sv
`timescale 1ns/1ps
module led_rotator_tb;
  localparam int N    = 8;
  localparam int TICK = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable_sw = 1'b0, btn_reverse = 1'b0, btn_report = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_arg = 8'd0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic [1:0] rsp_kind;
  logic [15:0] rsp_data;
  logic [N-1:0] led;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  led_rotator #(.NUM_LEDS(N), .TICK_CYCLES(TICK), .ARG_W(8), .CNT_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable_sw(enable_sw), .btn_reverse(btn_reverse),
    .btn_report(btn_report), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_kind(rsp_kind), .rsp_data(rsp_data), .led(led));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [7:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0;
  endtask

  task automatic take_rsp(input string req, input int kind, input int data);
    int n = 0;
    while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
    check(rsp_valid, req, int'(rsp_valid), 1);
    check(rsp_kind == 2'(kind), req, int'(rsp_kind), kind);
    check(rsp_data == 16'(data), req, int'(rsp_data), data);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic press(ref logic b);
    @(negedge clk); b = 1'b1;
    repeat (6) @(negedge clk);
    b = 1'b0;
  endtask

  task automatic wait_change(output int n);
    logic [N-1:0] old = led;
    n = 0;
    while (led == old && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    check(led == 8'h01, "R2 reset led", int'(led), 1);
    check(!rsp_valid, "R9 reset rsp_valid", int'(rsp_valid), 0);
    check(cmd_ready, "R9 reset cmd_ready", int'(cmd_ready), 1);
  endtask

  task automatic t_disabled();
    repeat (50) @(negedge clk);
    check(led == 8'h01, "R1 no move while off", int'(led), 1);
    send(2'd1, 8'd0);
    take_rsp("R6 read at reset", 1, 0);
  endtask

  task automatic t_write();
    send(2'd2, 8'd5);
    check(led == 8'h20, "R7 write 5 led", int'(led), 32);
    send(2'd1, 8'd0);
    take_rsp("R6 read after write", 1, 5);
    send(2'd2, 8'd9);
    send(2'd0, 8'd2);
    send(2'd1, 8'd0);
    take_rsp("R7 out-of-range and none ignored", 1, 5);
  endtask

  task automatic t_step_up_wrap();
    int n;
    send(2'd2, 8'd6);
    enable_sw = 1'b1;
    wait_change(n);
    check(led == 8'h80, "R2 step up to 7", int'(led), 128);
    wait_change(n);
    enable_sw = 1'b0;
    check(led == 8'h01, "R3 wrap up to 0", int'(led), 1);
    check(n == TICK, "R2 tick period", n, TICK);
    repeat (30) @(negedge clk);
    check(led == 8'h01, "R1 stops after off", int'(led), 1);
  endtask

  task automatic t_button_reverse();
    int n;
    press(btn_reverse);
    repeat (3) @(negedge clk);
    press(btn_report);
    take_rsp("R5 count cleared by button", 2, 0);
    enable_sw = 1'b1;
    wait_change(n);
    check(led == 8'h80, "R3 wrap down to 7", int'(led), 128);
    wait_change(n);
    enable_sw = 1'b0;
    check(led == 8'h40, "R4 one press one flip", int'(led), 64);
    repeat (10) @(negedge clk);
    press(btn_report);
    take_rsp("R8 steps since reversal", 2, 2);
  endtask

  task automatic t_cmd_reverse();
    int n;
    send(2'd3, 8'd0);
    enable_sw = 1'b1;
    wait_change(n);
    enable_sw = 1'b0;
    check(led == 8'h80, "R5 command reverse goes up", int'(led), 128);
    repeat (10) @(negedge clk);
    press(btn_report);
    take_rsp("R5 count restarts after command", 2, 1);
  endtask

  task automatic t_handshake();
    send(2'd1, 8'd0);
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      if (i == 1) cmd_valid = 1'b1;
      cmd_op = 2'd2; cmd_arg = 8'd2;
      @(negedge clk);
      check(rsp_valid && rsp_data == 16'd7, "R9 response held", int'(rsp_data), 7);
      check(!cmd_ready, "R9 cmd_ready low while pending", int'(cmd_ready), 0);
    end
    cmd_valid = 1'b0; cmd_op = 2'd0;
    take_rsp("R9 held response", 1, 7);
    send(2'd1, 8'd0);
    take_rsp("R9 blocked write not taken", 1, 7);
  endtask

  task automatic t_write_not_counted();
    send(2'd2, 8'd3);
    check(led == 8'h08, "R7 write 3 led", int'(led), 8);
    press(btn_report);
    take_rsp("R8 write does not count", 2, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_write();
    t_step_up_wrap();
    t_button_reverse();
    t_cmd_reverse();
    t_handshake();
    t_write_not_counted();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    while (cycles < 20000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 20000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule